// File: doc/BRIEF.md
# Quadrature Phase Lock Detector

This block watches two slow logic-level square waves, each near 1 kHz, and decides whether the second wave trails the first by one quarter of a cycle. It needs a system clock much faster than the inputs. Both inputs are brought into the clock domain, and their rising edges are found. The block then counts the spacing between rising edges of the first wave, which gives the period. It also counts the time from a rising edge of the first wave to the next rising edge of the second wave, which gives the delay.

At every rising edge of the first wave, the period that just ended is judged. The expected quarter-cycle count is subtracted from the measured delay. The result is a signed phase error, published with a one-cycle strobe so that a microcontroller link can pick it up. A separate flag shows whether the delay sits nearer three quarters of the period than one quarter, which is the wrong quadrant.

A lock flag, suitable for an LED, rises only after a run of consecutive periods whose error is inside a programmable tolerance. It falls at the first period that misses the tolerance, lands in the wrong quadrant, or cannot be measured. With a clock of 3.6 MHz or more, one count is at most 0.1 degree.

Top module: `quad_lock_det`

## Requirements
- R1: While rst_ni is low, and after reset until the first valid measurement, lock_o, phase_err_vld_o, quad_far_o and phase_err_o are all 0.
- R2: Let P be the clock count between two rising edges of sig_a_i. Let D be the clock count from the earlier of those two edges to the last rising edge of sig_b_i before the later one. A B edge in the same cycle as the later A edge counts as D = P. phase_err_vld_o pulses high for exactly one cycle per valid measurement, within 4 cycles after the later A edge. The first A edge after reset produces no measurement.
- R3: phase_err_o is a two's-complement value CNT_W+1 bits wide, equal to D - floor(P/4). It is updated only together with phase_err_vld_o and held otherwise.
- R4: quad_far_o is updated with each valid measurement to 1 when D > floor(P/2), and to 0 otherwise.
- R5: A measurement is in tolerance when it is valid, quad_far_o is 0 for it, and |phase_err| <= tol_i. lock_o rises together with the strobe of the 4th consecutive in-tolerance measurement.
- R6: A valid measurement that is not in tolerance clears lock_o and restarts the run count.
- R7: A period is invalid when P < 64 or no B edge occurred during it. An invalid period gives no strobe, leaves phase_err_o and quad_far_o unchanged, and clears lock_o.
- R8: If no rising edge of sig_a_i arrives for 65535 counts, lock_o clears without waiting for the next edge.
- R9: lock_o is never high while quad_far_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_a_i | input | 1 | Reference square wave, asynchronous |
| sig_b_i | input | 1 | Lagging square wave, asynchronous |
| tol_i | input | CNT_W | Accepted absolute phase error in counts |
| lock_o | output | 1 | Quarter-cycle lock indication |
| phase_err_o | output | CNT_W+1 | Signed delay minus quarter period |
| phase_err_vld_o | output | 1 | One-cycle strobe for a new phase error |
| quad_far_o | output | 1 | Delay is nearer three quarters of a period |

## Verification
The bench probes the tolerance edge from both sides: an error equal to the tolerance must lock, and one count more must not. A design using a strict compare, or taking the magnitude of a negative error wrongly, fails one of these. It checks that exactly four good periods lock and three do not, which exposes an off-by-one in the run counter. A delay of three quarters with a huge tolerance must not lock, which catches a missing quadrant veto. Short periods, a vanished B wave and a stopped A wave must drop or withhold lock. The stopped-A case must drop lock through the timeout rather than wait forever for another edge.

// File: rtl/qld_pkg.sv
package qld_pkg;
  localparam int unsigned DEF_CNT_W     = 16;
  localparam int unsigned DEF_MIN_PER   = 64;
  localparam int unsigned DEF_LOCK_RUNS = 4;
  localparam int unsigned DEF_SYNC      = 2;

  typedef enum logic [1:0] {
    JDG_IDLE = 2'd0,
    JDG_PASS = 2'd1,
    JDG_MISS = 2'd2,
    JDG_BAD  = 2'd3
  } jdg_e;
endpackage

// File: rtl/qld_edge.sv
module qld_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/qld_meas.sv
module qld_meas #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_PER = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_rise_i,
  input  logic             b_rise_i,
  output logic             evt_o,
  output logic             ok_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] dly_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(MIN_PER);

  logic [CNT_W-1:0] per_cnt_q;
  logic [CNT_W-1:0] dly_cap_q;
  logic             b_seen_q;
  logic             primed_q;
  logic             have_b;
  logic             tmo;

  assign have_b = b_seen_q | b_rise_i;
  // counter about to saturate: edge is missing
  assign tmo    = ~a_rise_i & (per_cnt_q == CNT_MAX - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt_q <= '0;
      dly_cap_q <= '0;
      b_seen_q  <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      if (a_rise_i) begin
        per_cnt_q <= CNT_W'(1);
        primed_q  <= 1'b1;
      end else if (per_cnt_q != CNT_MAX) begin
        per_cnt_q <= per_cnt_q + 1'b1;
      end
      if (b_rise_i) dly_cap_q <= per_cnt_q;
      b_seen_q <= a_rise_i ? 1'b0 : have_b;
    end
  end

  assign evt_o = (a_rise_i & primed_q) | tmo;
  assign ok_o  = a_rise_i & primed_q & have_b &
                 (per_cnt_q >= PER_MIN) & (per_cnt_q != CNT_MAX);
  assign per_o = per_cnt_q;
  assign dly_o = b_rise_i ? per_cnt_q : dly_cap_q;
endmodule

// File: rtl/qld_judge.sv
module qld_judge
  import qld_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LOCK_RUNS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] tol_i,
  output logic             lock_o,
  output logic [CNT_W:0]   err_o,
  output logic             err_vld_o,
  output logic             quad_far_o
);
  localparam int unsigned EW  = CNT_W + 1;
  localparam int unsigned RUW = $clog2(LOCK_RUNS + 1);
  localparam logic [RUW-1:0] RUN_TOP = RUW'(LOCK_RUNS);

  logic signed [EW-1:0] err_c;
  logic        [EW-1:0] mag_c;
  logic                 far_c;
  logic                 in_tol_c;
  jdg_e                 jdg;
  logic [RUW-1:0]       run_q;
  logic [RUW-1:0]       run_nxt;

  assign err_c    = $signed({1'b0, dly_i}) - $signed({3'b000, per_i[CNT_W-1:2]});
  assign mag_c    = err_c[EW-1] ? EW'(-err_c) : EW'(err_c);
  assign far_c    = dly_i > {1'b0, per_i[CNT_W-1:1]};
  assign in_tol_c = ~far_c & (mag_c <= {1'b0, tol_i});
  assign run_nxt  = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;

  always_comb begin
    if (!evt_i)         jdg = JDG_IDLE;
    else if (!ok_i)     jdg = JDG_BAD;
    else if (in_tol_c)  jdg = JDG_PASS;
    else                jdg = JDG_MISS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= '0;
      err_vld_o  <= 1'b0;
      quad_far_o <= 1'b0;
      run_q      <= '0;
      lock_o     <= 1'b0;
    end else begin
      err_vld_o <= 1'b0;
      if (jdg == JDG_PASS || jdg == JDG_MISS) begin
        err_vld_o  <= 1'b1;
        err_o      <= err_c;
        quad_far_o <= far_c;
      end
      unique case (jdg)
        JDG_PASS: begin
          run_q  <= run_nxt;
          lock_o <= (run_nxt == RUN_TOP);
        end
        JDG_MISS, JDG_BAD: begin
          run_q  <= '0;
          lock_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/quad_lock_det.sv
module quad_lock_det
  import qld_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned MIN_PER   = DEF_MIN_PER,
  parameter int unsigned LOCK_RUNS = DEF_LOCK_RUNS,
  parameter int unsigned SYNC      = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_a_i,
  input  logic             sig_b_i,
  input  logic [CNT_W-1:0] tol_i,
  output logic             lock_o,
  output logic [CNT_W:0]   phase_err_o,
  output logic             phase_err_vld_o,
  output logic             quad_far_o
);
  logic [1:0]       sig_in;
  logic [1:0]       rise;
  logic             evt;
  logic             ok;
  logic [CNT_W-1:0] per;
  logic [CNT_W-1:0] dly;

  assign sig_in = {sig_b_i, sig_a_i};

  // identical paths keep A-to-B delay exact in counts
  for (genvar c = 0; c < 2; c++) begin : g_chan
    qld_edge #(.STAGES(SYNC)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sig_in[c]),
      .rise_o (rise[c])
    );
  end

  qld_meas #(.CNT_W(CNT_W), .MIN_PER(MIN_PER)) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_rise_i (rise[0]),
    .b_rise_i (rise[1]),
    .evt_o    (evt),
    .ok_o     (ok),
    .per_o    (per),
    .dly_o    (dly)
  );

  qld_judge #(.CNT_W(CNT_W), .LOCK_RUNS(LOCK_RUNS)) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .ok_i       (ok),
    .per_i      (per),
    .dly_i      (dly),
    .tol_i      (tol_i),
    .lock_o     (lock_o),
    .err_o      (phase_err_o),
    .err_vld_o  (phase_err_vld_o),
    .quad_far_o (quad_far_o)
  );
endmodule

// File: rtl/qld_chk.sv
module qld_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tol_i,
  input logic             lock_o,
  input logic [CNT_W:0]   phase_err_o,
  input logic             phase_err_vld_o,
  input logic             quad_far_o
);
  logic [CNT_W:0] err_mag;
  assign err_mag = phase_err_o[CNT_W] ? -phase_err_o : phase_err_o;

  // R2
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_err_vld_o |=> !phase_err_vld_o);

  // R3
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_err_vld_o |-> $stable(phase_err_o));

  // R5
  lock_rise_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> phase_err_vld_o);

  // R6
  lock_in_tol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && phase_err_vld_o) |-> (err_mag <= {1'b0, tol_i}));

  // R9
  lock_quad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !quad_far_o);
endmodule

bind quad_lock_det qld_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .tol_i           (tol_i),
  .lock_o          (lock_o),
  .phase_err_o     (phase_err_o),
  .phase_err_vld_o (phase_err_vld_o),
  .quad_far_o      (quad_far_o)
);

// File: tb/quad_lock_det_tb.sv
module quad_lock_det_tb;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sig_a_i = 1'b0;
  logic          sig_b_i = 1'b0;
  logic [CW-1:0] tol_i = '0;
  logic          lock_o;
  logic [CW:0]   phase_err_o;
  logic          phase_err_vld_o;
  logic          quad_far_o;

  int total = 0;
  int bad   = 0;
  int vld_cnt = 0;
  int last_err = 0;
  int last_quad = 0;
  int lock_mid = 0;

  always #5 clk_i = ~clk_i;

  quad_lock_det u_dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sig_a_i         (sig_a_i),
    .sig_b_i         (sig_b_i),
    .tol_i           (tol_i),
    .lock_o          (lock_o),
    .phase_err_o     (phase_err_o),
    .phase_err_vld_o (phase_err_vld_o),
    .quad_far_o      (quad_far_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni && phase_err_vld_o) begin
      vld_cnt   <= vld_cnt + 1;
      last_err  <= int'($signed(phase_err_o));
      last_quad <= int'(quad_far_o);
    end
  end

  // fields: period, delay, periods, tol, exp strobes, exp err, exp quad, exp lock
  localparam int NV = 10;
  localparam int VEC [NV][8] = '{
    '{400, 100, 5,   2, 5,   0, 0, 1},
    '{400, 102, 5,   2, 5,   2, 0, 1},
    '{400, 103, 5,   2, 5,   3, 0, 0},
    '{400,  97, 5,   3, 5,  -3, 0, 1},
    '{400, 300, 5,   2, 5, 200, 1, 0},
    '{400, 100, 3,   2, 3,   0, 0, 0},
    '{401, 100, 4,   0, 4,   0, 0, 1},
    '{360, 201, 5, 500, 5, 111, 1, 0},
    '{400, 200, 4, 100, 4, 100, 0, 1},
    '{ 60,  15, 5,   2, 0,   0, 0, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    sig_a_i = 1'b0;
    sig_b_i = 1'b0;
    repeat (3) @(negedge clk_i);
    vld_cnt   = 0;
    last_err  = 0;
    last_quad = 0;
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // d >= p means B held low from period nsw on
  task automatic run_wave(input int p, input int d1, input int d2,
                          input int nsw, input int n);
    for (int t = 0; t <= n * p; t++) begin
      int d;
      @(negedge clk_i);
      d = (t < nsw * p) ? d1 : d2;
      sig_a_i = ((t % p) < p / 2);
      if (d >= p || t < d) sig_b_i = 1'b0;
      else                 sig_b_i = (((t - d) % p) < p / 2);
      if (t == nsw * p + 8) lock_mid = int'(lock_o);
    end
    repeat (8) @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 lock in reset", int'(lock_o), 0);
    chk("R1 strobe in reset", int'(phase_err_vld_o), 0);
    chk("R1 err in reset", int'(phase_err_o), 0);
    chk("R1 quad in reset", int'(quad_far_o), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      tol_i = CW'(VEC[i][3]);
      run_wave(VEC[i][0], VEC[i][1], VEC[i][1], VEC[i][2] + 1, VEC[i][2]);
      chk($sformatf("R2/R7 strobes vec%0d", i), vld_cnt, VEC[i][4]);
      chk($sformatf("R3 err vec%0d", i), last_err, VEC[i][5]);
      chk($sformatf("R4 quad vec%0d", i), last_quad, VEC[i][6]);
      chk($sformatf("R5/R9 lock vec%0d", i), int'(lock_o), VEC[i][7]);
    end

    // R6: locked, then delay jumps 30 counts outside a tolerance of 2
    do_reset();
    tol_i = CW'(2);
    run_wave(400, 100, 130, 6, 7);
    chk("R6 lock before step", lock_mid, 1);
    chk("R6 lock after step", int'(lock_o), 0);
    chk("R6 err after step", last_err, 30);

    // R7: locked, then B disappears
    do_reset();
    run_wave(400, 100, 999, 6, 8);
    chk("R7 lock before B loss", lock_mid, 1);
    chk("R7 lock after B loss", int'(lock_o), 0);
    chk("R7 strobes with B loss", vld_cnt, 6);
    chk("R7 err held", last_err, 0);

    // R8: locked, then A stops
    do_reset();
    run_wave(400, 100, 100, 6, 5);
    chk("R8 lock before stop", int'(lock_o), 1);
    sig_a_i = 1'b0;
    sig_b_i = 1'b0;
    repeat (60000) @(negedge clk_i);
    chk("R8 lock before timeout", int'(lock_o), 1);
    repeat (6000) @(negedge clk_i);
    chk("R8 lock after timeout", int'(lock_o), 0);
    chk("R8 no strobe on timeout", vld_cnt, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule